// File: doc/BRIEF.md
# Packed SIMD Integer Arithmetic Unit

This unit performs lane-wise integer arithmetic on wide packed operands. A caller presents two 128-bit operands and a 2-bit operation code with `in_valid` high. One clock later the unit raises `out_valid` and drives the packed result. Three operations are available. The first is a saturating add of four signed 16-bit lanes. The second is a multiply of four signed 32-bit lanes that keeps the low word of each product. The third is an average of eight unsigned byte lanes that rounds halves upward.

The add and the average use only the low 64 bits of each operand and return a 64-bit result. The multiply uses the full 128 bits. Lanes are independent. Lane 0 sits in the least significant bits, and no carry or borrow crosses from one lane into the next. The unit is meant to sit behind an instruction decoder and operand routing, which lie outside this block.

Top module: `simd_lane_alu`

## Requirements
- R1: Opcode 0 adds the signed 16-bit lanes of `opnd_a[63:0]` and `opnd_b[63:0]`. Lane i occupies bits [16i+15:16i] of the operands and of the result, and each result lane is the exact sum when that sum lies within 16-bit signed range.
- R2: Under opcode 0, a lane sum above 32767 yields 16'h7FFF and a lane sum below -32768 yields 16'h8000; no lane wraps.
- R3: Opcode 1 multiplies the signed 32-bit lanes of the full 128-bit operands. Lane i occupies bits [32i+31:32i], and each result lane holds the low 32 bits of the signed product.
- R4: Opcode 2 forms (a+b+1)>>1 for each unsigned byte lane of `opnd_a[63:0]` and `opnd_b[63:0]`, with lane i at bits [8i+7:8i]; the sum is computed with no loss of the ninth bit.
- R5: A carry, borrow or overflow in one lane has no effect on any other lane.
- R6: Under opcodes 0 and 2, `result[127:64]` is zero and operand bits [127:64] have no effect on the result.
- R7: Opcode 3 is reserved and yields an all-zero result.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `result` holds that operation's value in the same cycle.
- R9: In a cycle with `in_valid` low, `out_valid` goes low one cycle later and `result` keeps its previous value.
- R10: While `rst_n` is low, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| op | input | 2 | 0 add16 saturating, 1 mul32 low word, 2 byte average, 3 reserved |
| opnd_a | input | 128 | First packed operand |
| opnd_b | input | 128 | Second packed operand |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 128 | Packed result |

## Verification
Several properties are asserted on every cycle. The one-cycle latency of `out_valid` and the holding of the result while idle are checked. The upper half of the result must be zero for the narrow operations and the whole result must be zero for the reserved code. Each add lane that saturates must give the matching bound. Each byte average must lie between its two inputs. Each multiply lane that has a zero input must give zero. Exact lane values cannot be shown by these properties. Only the bench scenarios, compared against an independent lane-by-lane model, can show the exact values, the rounding direction of the average, the absence of carries between lanes, and the operand bits that are ignored.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_ADD16S = 2'd0,
    OP_MUL32L = 2'd1,
    OP_AVGU8  = 2'd2,
    OP_RSVD   = 2'd3
  } simd_op_e;

  localparam int ADD_LW = 16;
  localparam int MUL_LW = 32;
  localparam int AVG_LW = 8;
endpackage

// File: rtl/simd_add_sat.sv
module simd_add_sat #(
  parameter int LANES = 4,
  parameter int LW    = 16
) (
  input  logic [LANES*LW-1:0] a,
  input  logic [LANES*LW-1:0] b,
  output logic [LANES*LW-1:0] y
);
  localparam logic [LW-1:0] MAXV = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] MINV = {1'b1, {(LW-1){1'b0}}};

  function automatic logic [LW-1:0] clamp(input logic [LW:0] s);
    if (s[LW:LW-1] == 2'b01)      clamp = MAXV;
    else if (s[LW:LW-1] == 2'b10) clamp = MINV;
    else                          clamp = s[LW-1:0];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] la, lb, ly;
    logic [LW:0]   sum_ext;
    logic          ovf_hi, ovf_lo;
    assign la      = a[g*LW +: LW];
    assign lb      = b[g*LW +: LW];
    assign sum_ext = {la[LW-1], la} + {lb[LW-1], lb};
    assign ovf_hi  = ~la[LW-1] & ~lb[LW-1] & sum_ext[LW-1];
    assign ovf_lo  = la[LW-1] & lb[LW-1] & ~sum_ext[LW-1];
    assign ly      = clamp(sum_ext);
    assign y[g*LW +: LW] = ly;

    always_comb begin
      if (ovf_hi) assert_sat_high_R2: assert (ly == MAXV)
        else $error("lane %0d positive overflow not clamped", g);
      if (ovf_lo) assert_sat_low_R2: assert (ly == MINV)
        else $error("lane %0d negative overflow not clamped", g);
    end
  end
endmodule

// File: rtl/simd_mul_lo.sv
module simd_mul_lo #(
  parameter int LANES = 4,
  parameter int LW    = 32
) (
  input  logic [LANES*LW-1:0] a,
  input  logic [LANES*LW-1:0] b,
  output logic [LANES*LW-1:0] y
);
  function automatic logic [LW-1:0] mul_low(input logic [LW-1:0] x, input logic [LW-1:0] z);
    logic signed [2*LW-1:0] p;
    p = $signed(x) * $signed(z);
    mul_low = p[LW-1:0];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] la, lb, ly;
    assign la = a[g*LW +: LW];
    assign lb = b[g*LW +: LW];
    assign ly = mul_low(la, lb);
    assign y[g*LW +: LW] = ly;

    always_comb begin
      if (la == '0 || lb == '0) assert_zero_factor_R3: assert (ly == '0)
        else $error("lane %0d zero factor gave nonzero product", g);
    end
  end
endmodule

// File: rtl/simd_avg_u8.sv
module simd_avg_u8 #(
  parameter int LANES = 8,
  parameter int LW    = 8
) (
  input  logic [LANES*LW-1:0] a,
  input  logic [LANES*LW-1:0] b,
  output logic [LANES*LW-1:0] y
);
  function automatic logic [LW-1:0] avg_up(input logic [LW-1:0] x, input logic [LW-1:0] z);
    logic [LW:0] s;
    s = {1'b0, x} + {1'b0, z} + {{LW{1'b0}}, 1'b1};
    avg_up = s[LW:1];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] la, lb, ly, lo_in, hi_in;
    assign la    = a[g*LW +: LW];
    assign lb    = b[g*LW +: LW];
    assign ly    = avg_up(la, lb);
    assign lo_in = (la < lb) ? la : lb;
    assign hi_in = (la < lb) ? lb : la;
    assign y[g*LW +: LW] = ly;

    always_comb begin
      assert_avg_bounded_R4: assert (ly >= lo_in && ly <= hi_in)
        else $error("lane %0d average outside inputs", g);
    end
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  output logic [W-1:0] result
);
  localparam int HALF      = W / 2;
  localparam int ADD_LANES = HALF / ADD_LW;
  localparam int MUL_LANES = W / MUL_LW;
  localparam int AVG_LANES = HALF / AVG_LW;

  logic [HALF-1:0] add_y, avg_y;
  logic [W-1:0]    mul_y, next_y;
  simd_op_e        op_e, op_q;

  assign op_e = simd_op_e'(op);

  simd_add_sat #(.LANES(ADD_LANES), .LW(ADD_LW)) u_add (
    .a(opnd_a[HALF-1:0]), .b(opnd_b[HALF-1:0]), .y(add_y));

  simd_mul_lo #(.LANES(MUL_LANES), .LW(MUL_LW)) u_mul (
    .a(opnd_a), .b(opnd_b), .y(mul_y));

  simd_avg_u8 #(.LANES(AVG_LANES), .LW(AVG_LW)) u_avg (
    .a(opnd_a[HALF-1:0]), .b(opnd_b[HALF-1:0]), .y(avg_y));

  always_comb begin
    case (op_e)
      OP_ADD16S: next_y = {{HALF{1'b0}}, add_y};
      OP_MUL32L: next_y = mul_y;
      OP_AVGU8:  next_y = {{HALF{1'b0}}, avg_y};
      default:   next_y = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      op_q      <= OP_ADD16S;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= next_y;
        op_q   <= op_e;
      end
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q != OP_MUL32L) |-> (result[W-1:HALF] == '0));

  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_RSVD) |-> (result == '0));
endmodule

// File: tb/simd_lane_alu_bench.sv
module simd_lane_alu_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   op;
  logic [127:0] opnd_a, opnd_b;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  simd_lane_alu u_simd_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result));

  function automatic logic [127:0] ref_add(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      int s;
      s = int'($signed(a[16*i +: 16])) + int'($signed(b[16*i +: 16]));
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      r[16*i +: 16] = s[15:0];
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      longint p;
      p = longint'($signed(a[32*i +: 32])) * longint'($signed(b[32*i +: 32]));
      r[32*i +: 32] = p[31:0];
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_avg(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int s;
      s = int'(a[8*i +: 8]) + int'(b[8*i +: 8]) + 1;
      r[8*i +: 8] = s[8:1];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One operation: drive at a falling edge, sample at the next falling edge
  // (one rising edge later), then confirm the idle cycle keeps the result.
  task automatic run_op(input logic [1:0] code, input logic [127:0] a, input logic [127:0] b,
                        input logic [127:0] exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; op = code; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0; opnd_a = ~a; opnd_b = ~b; op = ~code;
    check(out_valid == 1'b1, "R8 out_valid after in_valid", 128'(out_valid), 128'd1);
    check(result == exp, req, result, exp);
    @(negedge clk);
    check(out_valid == 1'b0 && result == exp, "R9 idle hold", result, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b1; op = 2'd1;
    opnd_a = {4{32'd7}}; opnd_b = {4{32'd9}};
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid in reset", 128'(out_valid), 128'd0);
    check(result == '0, "R10 result in reset", result, '0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 idle after reset", 128'(out_valid), 128'd0);
  endtask

  task automatic t_add();
    run_op(2'd0, {64'd0, 64'h0010_FFF0_0005_0003}, {64'd0, 64'h0020_0003_FFFE_0004},
           {64'd0, 64'h0030_FFF3_0003_0007}, "R1 add in range");
    run_op(2'd0, {64'd0, 64'h1234_7000_8000_7FFF}, {64'd0, 64'h0001_7000_FFFF_0001},
           {64'd0, 64'h1235_7FFF_8000_7FFF}, "R2 add saturation");
    run_op(2'd0, {64'd0, 64'h0000_0000_FFFF_FFFF}, {64'd0, 64'h0000_0000_0001_0001},
           '0, "R5 add no carry across lanes");
  endtask

  task automatic t_mul();
    logic [127:0] a = {32'h0001_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd3};
    logic [127:0] b = {32'h0001_0000, 32'd5, 32'd2, 32'hFFFF_FFFE};
    run_op(2'd1, a, b, {32'd0, 32'hFFFF_FFFB, 32'hFFFF_FFFE, 32'hFFFF_FFFA}, "R3 mul low word");
    check(ref_mul(a, b) == {32'd0, 32'hFFFF_FFFB, 32'hFFFF_FFFE, 32'hFFFF_FFFA},
          "R5 mul model agrees", ref_mul(a, b), {32'd0, 32'hFFFF_FFFB, 32'hFFFF_FFFE, 32'hFFFF_FFFA});
  endtask

  task automatic t_avg();
    run_op(2'd2, {64'd0, 64'hFF00_FF01_0203_0410}, {64'd0, 64'hFF01_0001_0204_0512},
           {64'd0, 64'hFF01_8001_0204_0511}, "R4 byte average rounds up");
  endtask

  task automatic t_upper();
    logic [127:0] a = {64'hDEAD_BEEF_0123_4567, 64'h0102_0304_0506_0708};
    logic [127:0] b = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101};
    run_op(2'd0, a, b, ref_add({64'd0, a[63:0]}, {64'd0, b[63:0]}), "R6 add ignores upper bits");
    run_op(2'd2, a, b, ref_avg({64'd0, a[63:0]}, {64'd0, b[63:0]}), "R6 avg ignores upper bits");
  endtask

  task automatic t_reserved();
    run_op(2'd3, {128{1'b1}}, {4{32'h1357_9BDF}}, '0, "R7 reserved opcode");
  endtask

  task automatic t_back_to_back();
    logic [127:0] a1 = {4{32'h0000_1234}};
    logic [127:0] b1 = {4{32'h0000_0010}};
    logic [127:0] a2 = {64'd0, 64'h7FFF_7FFF_7FFF_7FFF};
    @(negedge clk);
    in_valid = 1'b1; op = 2'd1; opnd_a = a1; opnd_b = b1;
    @(negedge clk);
    check(out_valid == 1'b1 && result == ref_mul(a1, b1), "R8 first of pair", result, ref_mul(a1, b1));
    op = 2'd0; opnd_a = a2; opnd_b = a2;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && result == ref_add(a2, a2), "R8 second of pair", result, ref_add(a2, a2));
    @(negedge clk);
    check(out_valid == 1'b0, "R9 drops after pair", 128'(out_valid), 128'd0);
  endtask

  task automatic t_mixed();
    for (int n = 0; n < 60; n++) begin
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
      case (n % 3)
        0: run_op(2'd0, a, b, ref_add({64'd0, a[63:0]}, {64'd0, b[63:0]}), "R1 mixed add");
        1: run_op(2'd1, a, b, ref_mul(a, b), "R3 mixed mul");
        default: run_op(2'd2, a, b, ref_avg({64'd0, a[63:0]}, {64'd0, b[63:0]}), "R4 mixed avg");
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_mul();
    t_avg();
    t_upper();
    t_reserved();
    t_back_to_back();
    t_mixed();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule